// File: doc/BRIEF.md
# Fast Interrupt Source Selector

This block picks one interrupt source out of a flat set of 72 raw level inputs and sends it to a dedicated fast-interrupt output. The sources come in three groups: a small group of 8 and two wide groups of 32. A single control register, written and read through a simple register port, holds a 7-bit source number and a separate enable bit. While the enable bit is set and the number names a real source, the fast output follows that source's raw level. The per-source masks of the normal interrupt path have no effect on it.

The block also forms the normal interrupt request, the OR of every source ANDed with its normal-path enable. Both outputs pass through one register stage of equal depth. If software selects a source for the fast path without first removing it from the normal path, both outputs rise in the same cycle. That is the hazard the integrating software must avoid.

Top module: `fiqsel_top`

## Requirements
- R1: While reset is asserted and right after it, the control register reads 0, and `fiq_o` and `irq_o` are low.
- R2: A write at byte offset 0x0C stores bits 6:0 of the write data as the source number and bit 7 as the fast enable. A read at offset 0x0C returns these 8 bits in the same positions, with bits 31:8 reading zero. The read is combinational on the current register contents.
- R3: A write at any offset other than 0x0C leaves the control register unchanged, and a read at any other offset returns zero.
- R4: Source numbers 0 to 31 select `src_b1_i[n]`, 32 to 63 select `src_b2_i[n-32]`, and 64 to 71 select `src_b0_i[n-64]`.
- R5: When the enable bit is set and the number is below 72, `fiq_o` one clock edge later equals the selected source's level at that edge.
- R6: When the enable bit is clear, `fiq_o` is low one edge later, whatever the source levels are.
- R7: A source number of 72 or above never drives `fiq_o` high, even with every source high.
- R8: `fiq_o` does not depend on `irq_en_i`. It fires with all normal-path enables clear.
- R9: `irq_o` one edge later is the OR over all sources of the level ANDed with the matching bit of `irq_en_i`, whose bit order is the same as the source numbering of R4. A selected source that is also enabled on the normal path raises `fiq_o` and `irq_o` together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_b0_i | input | 8 | Raw levels, small group |
| src_b1_i | input | 32 | Raw levels, first wide group |
| src_b2_i | input | 32 | Raw levels, second wide group |
| irq_en_i | input | 72 | Normal-path enables in source-number order |
| reg_wr_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 8 | Write byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_raddr_i | input | 8 | Read byte offset |
| reg_rdata_o | output | 32 | Read data |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |

## Verification
The assertions check on every cycle that the register captures only writes that hit its offset and holds otherwise. They also check that the upper read bits stay zero, that a clear enable or an out-of-range number forces `fiq_o` low, that `fiq_o` tracks the selected level, and that a source enabled on both paths raises both outputs together. Only the bench's scenarios can show that each number lands on the correct group and bit. The bench's scenarios also show that the normal-path masks leave the fast output alone, and they exercise the simultaneous-firing hazard against independently computed expectations.

// File: rtl/fiqsel_pkg.sv
package fiqsel_pkg;

  localparam int unsigned GRP0_N = 8;
  localparam int unsigned GRP1_N = 32;
  localparam int unsigned GRP2_N = 32;

  // Source count and the width needed to number them.
  function automatic int unsigned total_sources(input int unsigned n0,
                                                input int unsigned n1,
                                                input int unsigned n2);
    return n0 + n1 + n2;
  endfunction

  function automatic int unsigned index_width(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/fiqsel_regs.sv
module fiqsel_regs #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned IDX_W    = 7,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              en_o,
  output logic              wr_hit_o
);

  localparam int unsigned CTRL_W = IDX_W + 1;

  logic [CTRL_W-1:0] ctrl_q;

  assign wr_hit_o = wr_i && (waddr_i == CTRL_OFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_hit_o) begin
      ctrl_q <= wdata_i[CTRL_W-1:0];
    end
  end

  assign idx_o = ctrl_q[IDX_W-1:0];
  assign en_o  = ctrl_q[IDX_W];

  always_comb begin
    rdata_o = '0;
    if (raddr_i == CTRL_OFS) begin
      rdata_o[CTRL_W-1:0] = ctrl_q;
    end
  end

endmodule

// File: rtl/fiqsel_src_mux.sv
module fiqsel_src_mux #(
  parameter int unsigned N0    = 8,
  parameter int unsigned N1    = 32,
  parameter int unsigned N2    = 32,
  parameter int unsigned SRC_N = N0 + N1 + N2,
  parameter int unsigned IDX_W = 7
) (
  input  logic [N0-1:0]    grp0_i,
  input  logic [N1-1:0]    grp1_i,
  input  logic [N2-1:0]    grp2_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [SRC_N-1:0] flat_o,
  output logic             in_range_o,
  output logic             level_o
);

  localparam int unsigned SPAN = 2 ** IDX_W;

  // Numbering order: first wide group, second wide group, small group.
  for (genvar g = 0; g < N1; g++) begin : g_grp1
    assign flat_o[g] = grp1_i[g];
  end
  for (genvar g = 0; g < N2; g++) begin : g_grp2
    assign flat_o[N1 + g] = grp2_i[g];
  end
  for (genvar g = 0; g < N0; g++) begin : g_grp0
    assign flat_o[N1 + N2 + g] = grp0_i[g];
  end

  logic [SPAN-1:0] padded;

  always_comb begin
    padded = '0;
    padded[SRC_N-1:0] = flat_o;
  end

  assign in_range_o = ({1'b0, idx_i} < (IDX_W + 1)'(SRC_N));
  assign level_o    = in_range_o && padded[idx_i];

endmodule

// File: rtl/fiqsel_out_stage.sv
module fiqsel_out_stage #(
  parameter int unsigned SRC_N = 72
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fiq_en_i,
  input  logic             level_i,
  input  logic [SRC_N-1:0] flat_i,
  input  logic [SRC_N-1:0] irq_en_i,
  output logic             irq_any_o,
  output logic             fiq_o,
  output logic             irq_o
);

  logic fiq_d;

  assign irq_any_o = |(flat_i & irq_en_i);
  assign fiq_d     = fiq_en_i && level_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fiq_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      fiq_o <= fiq_d;
      irq_o <= irq_any_o;
    end
  end

endmodule

// File: rtl/fiqsel_top.sv
module fiqsel_top
  import fiqsel_pkg::*;
#(
  parameter int unsigned N0       = GRP0_N,
  parameter int unsigned N1       = GRP1_N,
  parameter int unsigned N2       = GRP2_N,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h0C,
  localparam int unsigned SRC_N   = total_sources(N0, N1, N2),
  localparam int unsigned IDX_W   = index_width(SRC_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N0-1:0]     src_b0_i,
  input  logic [N1-1:0]     src_b1_i,
  input  logic [N2-1:0]     src_b2_i,
  input  logic [SRC_N-1:0]  irq_en_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_waddr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic [ADDR_W-1:0] reg_raddr_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              fiq_o,
  output logic              irq_o
);

  logic [IDX_W-1:0] ctrl_idx;
  logic             ctrl_en;
  logic             wr_hit;
  logic [SRC_N-1:0] flat_src;
  logic             in_range;
  logic             sel_level;
  logic             irq_any;

  fiqsel_regs #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .IDX_W   (IDX_W),
    .CTRL_OFS(CTRL_OFS)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (reg_wr_i),
    .waddr_i (reg_waddr_i),
    .wdata_i (reg_wdata_i),
    .raddr_i (reg_raddr_i),
    .rdata_o (reg_rdata_o),
    .idx_o   (ctrl_idx),
    .en_o    (ctrl_en),
    .wr_hit_o(wr_hit)
  );

  fiqsel_src_mux #(
    .N0   (N0),
    .N1   (N1),
    .N2   (N2),
    .SRC_N(SRC_N),
    .IDX_W(IDX_W)
  ) u_mux (
    .grp0_i    (src_b0_i),
    .grp1_i    (src_b1_i),
    .grp2_i    (src_b2_i),
    .idx_i     (ctrl_idx),
    .flat_o    (flat_src),
    .in_range_o(in_range),
    .level_o   (sel_level)
  );

  fiqsel_out_stage #(
    .SRC_N(SRC_N)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .fiq_en_i (ctrl_en),
    .level_i  (sel_level),
    .flat_i   (flat_src),
    .irq_en_i (irq_en_i),
    .irq_any_o(irq_any),
    .fiq_o    (fiq_o),
    .irq_o    (irq_o)
  );

endmodule

// File: rtl/fiqsel_checker.sv
module fiqsel_checker #(
  parameter int unsigned SRC_N  = 72,
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fiq_o,
  input logic              irq_o,
  input logic              wr_hit,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic [IDX_W-1:0]  ctrl_idx,
  input logic              ctrl_en,
  input logic              in_range,
  input logic              sel_level,
  input logic [SRC_N-1:0]  irq_en_i
);

  localparam int unsigned CTRL_W = IDX_W + 1;

  // R1: quiet outputs and cleared register while reset is held
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!fiq_o && !irq_o && !ctrl_en && ctrl_idx == '0)
        else $error("reset state violated");
    end
  end

  p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ({ctrl_en, ctrl_idx} == $past(reg_wdata_i[CTRL_W-1:0])));

  p_rdata_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata_o[DATA_W-1:CTRL_W] == '0);

  p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable({ctrl_en, ctrl_idx}));

  p_fiq_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && in_range) |=> (fiq_o == $past(sel_level)));

  p_fiq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> !fiq_o);

  p_fiq_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_idx >= IDX_W'(SRC_N)) |=> !fiq_o);

  p_both_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && in_range && sel_level && irq_en_i[ctrl_idx]) |=> (fiq_o && irq_o));

endmodule

bind fiqsel_top fiqsel_checker #(
  .SRC_N (SRC_N),
  .IDX_W (IDX_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fiq_o      (fiq_o),
  .irq_o      (irq_o),
  .wr_hit     (wr_hit),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .ctrl_idx   (ctrl_idx),
  .ctrl_en    (ctrl_en),
  .in_range   (in_range),
  .sel_level  (sel_level),
  .irq_en_i   (irq_en_i)
);

// File: tb/fiqsel_top_bench.sv
module fiqsel_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  b0 = '0;
  logic [31:0] b1 = '0;
  logic [31:0] b2 = '0;
  logic [71:0] en = '0;
  logic        wr = 1'b0;
  logic [7:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  raddr = 8'h0C;
  logic [31:0] rdata;
  logic        fiq, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model_ctrl = '0;

  always #2 clk = ~clk;

  fiqsel_top u_fiqsel_top (
    .clk(clk), .rst_n(rst_n),
    .src_b0_i(b0), .src_b1_i(b1), .src_b2_i(b2), .irq_en_i(en),
    .reg_wr_i(wr), .reg_waddr_i(waddr), .reg_wdata_i(wdata),
    .reg_raddr_i(raddr), .reg_rdata_o(rdata),
    .fiq_o(fiq), .irq_o(irq)
  );

  function automatic bit pick(input int n, input logic [7:0] s0,
                              input logic [31:0] s1, input logic [31:0] s2);
    if (n < 32) return s1[n];
    if (n < 64) return s2[n - 32];
    if (n < 72) return s0[n - 64];
    return 1'b0;
  endfunction

  function automatic bit want_fiq(input logic [7:0] c, input logic [7:0] s0,
                                  input logic [31:0] s1, input logic [31:0] s2);
    return c[7] && pick(int'(c[6:0]), s0, s1, s2);
  endfunction

  function automatic bit want_irq(input logic [71:0] e, input logic [7:0] s0,
                                  input logic [31:0] s1, input logic [31:0] s2);
    bit any = 0;
    for (int n = 0; n < 72; n++) any |= pick(n, s0, s1, s2) && e[n];
    return any;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One cycle: inputs already set after a falling edge; predict, clock, check.
  task automatic cycle(input string tag);
    bit ef, ei;
    ef = want_fiq(model_ctrl, b0, b1, b2);
    ei = want_irq(en, b0, b1, b2);
    if (wr && waddr == 8'h0C) model_ctrl = wdata[7:0];
    @(posedge clk); #1;
    chk({tag, " fiq"}, {31'd0, fiq}, {31'd0, ef});
    chk({tag, " irq"}, {31'd0, irq}, {31'd0, ei});
    if (raddr == 8'h0C) chk({tag, " rdata"}, rdata, {24'd0, model_ctrl});
    else chk({tag, " rdata other"}, rdata, 32'd0);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic write_ctrl(input logic [7:0] a, input logic [31:0] d, input string tag);
    wr = 1'b1; waddr = a; wdata = d;
    cycle(tag);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    b0 = '1; b1 = '1; b2 = '1; en = '1;
    repeat (3) @(negedge clk);
    chk("R1 fiq in reset", {31'd0, fiq}, 32'd0);
    chk("R1 irq in reset", {31'd0, irq}, 32'd0);
    chk("R1 ctrl in reset", rdata, 32'd0);
    b0 = '0; b1 = '0; b2 = '0; en = '0;
    rst_n = 1'b1;
    @(negedge clk);
    cycle("R1 after reset");

    // R2: upper write bits dropped
    write_ctrl(8'h0C, 32'hFFFF_FF85, "R2 write");
    chk("R2 readback", rdata, 32'h85);
    // R4/R5: number 5 -> first wide group bit 5
    b1[5] = 1'b1; cycle("R4 grp1 bit5 high");
    b1[5] = 1'b0; b1[4] = 1'b1; cycle("R5 neighbour only");
    // R4: number 40 -> second wide group bit 8
    write_ctrl(8'h0C, 32'h80 | 40, "R4 select 40");
    b1 = '0; b2[8] = 1'b1; cycle("R4 grp2 bit8");
    // R4: number 70 -> small group bit 6
    write_ctrl(8'h0C, 32'h80 | 70, "R4 select 70");
    b2 = '0; b0[6] = 1'b1; cycle("R4 grp0 bit6");
    // R8: enables clear, fast path still fires
    en = '0; cycle("R8 no irq enables");
    chk("R8 fiq high", {31'd0, fiq}, 32'd1);
    // R9: selected source also enabled normally -> both fire
    en[70] = 1'b1; cycle("R9 both fire");
    chk("R9 both high", {30'd0, fiq, irq}, 32'd3);
    // R3: other offset write ignored, other read is zero
    write_ctrl(8'h10, 32'h0000_0000, "R3 stray write");
    raddr = 8'h10; cycle("R3 stray read");
    raddr = 8'h0C; cycle("R3 still selected");
    chk("R3 fiq kept", {31'd0, fiq}, 32'd1);
    // R6: enable cleared, all sources high
    b0 = '1; b1 = '1; b2 = '1;
    write_ctrl(8'h0C, 32'h0000_0046, "R6 disable");
    cycle("R6 all high disabled");
    // R7: out-of-range numbers
    write_ctrl(8'h0C, 32'h80 | 72, "R7 select 72");
    cycle("R7 number 72");
    write_ctrl(8'h0C, 32'hFF, "R7 select 127");
    cycle("R7 number 127");
    chk("R7 fiq low", {31'd0, fiq}, 32'd0);

    // Random mix
    for (int k = 0; k < 400; k++) begin
      b0 = 8'($urandom); b1 = $urandom; b2 = $urandom;
      en = {8'($urandom), $urandom, $urandom} & {72{($urandom_range(0, 3) == 0)}};
      raddr = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'h0C;
      if ($urandom_range(0, 3) == 0) begin
        wr = 1'b1;
        waddr = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h0C;
        wdata = $urandom;
      end
      cycle("R5 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule